// File: doc/BRIEF.md
# UART DMA Request Generator

This block drives the DMA handshake lines of a UART. It watches the fill level of the receive FIFO and the fill level of the transmit FIFO. For each direction it raises two request lines. The single request means at least one character can be moved. The burst request means a programmed block of characters can be moved.

Each direction has its own threshold select and its own DMA enable. Each direction also has a clear pulse from the DMA controller, which drops that direction's requests for one cycle so the level is judged again. An optional gating mode holds the receive requests low while the UART error interrupt is pending. The transmit requests are never gated. All outputs are registered, so each output reflects the inputs sampled at the previous clock edge. The FIFO depth is a parameter and defaults to 16 entries.

Top module: `uart_dma_req`

## Requirements
- R1: While rst_ni is low, all four request outputs are 0.
- R2: With receive DMA enabled, no receive clear and no gating, rx_single_o is 1 one clock after rx_level_i is non-zero, and 0 one clock after it is zero.
- R3: With the same conditions, rx_burst_o is 1 one clock after rx_level_i is greater than or equal to the receive threshold, and 0 otherwise.
- R4: With transmit DMA enabled and no transmit clear, tx_single_o is 1 one clock after tx_level_i is below the FIFO depth (16), and 0 when the FIFO is full.
- R5: With the same conditions, tx_burst_o is 1 one clock after the free space (16 - tx_level_i) is greater than or equal to the transmit threshold.
- R6: The 3-bit threshold selects decode as follows: 0 gives 2 entries (1/8), 1 gives 4 (1/4), 2 gives 8 (1/2), 3 gives 12 (3/4), 4 gives 14 (7/8). The values 5 to 7 decode as 8 (1/2).
- R7: When err_mask_en_i and err_irq_i are both 1 in a cycle, both receive outputs are 0 in the next cycle. They stay 0 while the interrupt is held, and they follow the FIFO level again one clock after err_irq_i falls.
- R8: With err_mask_en_i at 0, err_irq_i has no effect on the receive outputs.
- R9: The transmit outputs are unaffected by err_mask_en_i and err_irq_i.
- R10: A 1 on rx_clr_i or tx_clr_i forces both outputs of that direction to 0 in the next cycle only. The other direction is unaffected.
- R11: When rx_dma_en_i or tx_dma_en_i is 0, both outputs of that direction are 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dma_en_i | input | 1 | Receive DMA enable |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| err_mask_en_i | input | 1 | Enables gating of receive requests by the error interrupt |
| err_irq_i | input | 1 | UART error interrupt |
| rx_level_i | input | 5 | Receive FIFO occupancy |
| tx_level_i | input | 5 | Transmit FIFO occupancy |
| rx_thr_sel_i | input | 3 | Receive burst threshold select |
| tx_thr_sel_i | input | 3 | Transmit burst threshold select |
| rx_clr_i | input | 1 | Receive request clear from the DMA controller |
| tx_clr_i | input | 1 | Transmit request clear from the DMA controller |
| rx_single_o | output | 1 | Receive single request |
| rx_burst_o | output | 1 | Receive burst request |
| tx_single_o | output | 1 | Transmit single request |
| tx_burst_o | output | 1 | Transmit burst request |

## Verification
Two receive-side functions can fall in the same cycle: a clear pulse and the falling edge of the error interrupt. The bench drops err_irq_i in the same cycle that it pulses rx_clr_i. It expects the receive outputs to stay 0 for one more cycle and to come back the cycle after. The bench also raises tx_clr_i while receive gating is active. It checks that the transmit outputs drop for exactly one cycle and that the gated receive outputs stay 0 throughout.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic [2:0] {
    THR_EIGHTH   = 3'd0,
    THR_QUARTER  = 3'd1,
    THR_HALF     = 3'd2,
    THR_3QUARTER = 3'd3,
    THR_7EIGHTH  = 3'd4
  } thr_sel_e;

  localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/uart_dma_thr_dec.sv
module uart_dma_thr_dec
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [LVL_W-1:0] thr_o
);
  localparam logic [LVL_W-1:0] T_1_8 = LVL_W'(DEPTH / 8);
  localparam logic [LVL_W-1:0] T_1_4 = LVL_W'(DEPTH / 4);
  localparam logic [LVL_W-1:0] T_1_2 = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] T_3_4 = LVL_W'((DEPTH * 3) / 4);
  localparam logic [LVL_W-1:0] T_7_8 = LVL_W'((DEPTH * 7) / 8);

  always_comb begin
    case (sel_i)
      THR_EIGHTH:   thr_o = T_1_8;
      THR_QUARTER:  thr_o = T_1_4;
      THR_HALF:     thr_o = T_1_2;
      THR_3QUARTER: thr_o = T_3_4;
      THR_7EIGHTH:  thr_o = T_7_8;
      default:      thr_o = T_1_2; // reserved codes fall back to half
    endcase
  end

  // R6
  thr_nonzero_chk: assert final (thr_o != '0);
endmodule

// File: rtl/uart_dma_dir.sv
module uart_dma_dir #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gate_i,
  input  logic             clr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             single_o,
  output logic             burst_o
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] avail;
  logic             single_cond;
  logic             burst_cond;
  logic             pass;

  generate
    if (IS_TX) begin : g_tx
      // room left to fill
      assign avail       = DEPTH_L - level_i;
      assign single_cond = level_i < DEPTH_L;
    end else begin : g_rx
      // entries waiting to drain
      assign avail       = level_i;
      assign single_cond = level_i != '0;
    end
  endgenerate

  assign burst_cond = avail >= thr_i;
  assign pass       = en_i && !clr_i && !gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o <= 1'b0;
      burst_o  <= 1'b0;
    end else begin
      single_o <= pass && single_cond;
      burst_o  <= pass && burst_cond;
    end
  end

  // R10
  clr_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!single_o && !burst_o));

  // R11
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!single_o && !burst_o));

  // R3 R5: a burst always implies at least one character movable
  burst_has_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_o |-> single_o);
endmodule

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dma_en_i,
  input  logic             tx_dma_en_i,
  input  logic             err_mask_en_i,
  input  logic             err_irq_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [SEL_W-1:0] rx_thr_sel_i,
  input  logic [SEL_W-1:0] tx_thr_sel_i,
  input  logic             rx_clr_i,
  input  logic             tx_clr_i,
  output logic             rx_single_o,
  output logic             rx_burst_o,
  output logic             tx_single_o,
  output logic             tx_burst_o
);
  localparam int unsigned N_DIR = 2; // 0 = rx, 1 = tx

  logic [N_DIR-1:0]            en, gate, clr, single, burst;
  logic [N_DIR-1:0][LVL_W-1:0] level, thr;
  logic [N_DIR-1:0][SEL_W-1:0] sel;

  assign en    = {tx_dma_en_i, rx_dma_en_i};
  assign clr   = {tx_clr_i, rx_clr_i};
  assign level = {tx_level_i, rx_level_i};
  assign sel   = {tx_thr_sel_i, rx_thr_sel_i};
  // transmit side is never gated by the error interrupt
  assign gate  = {1'b0, err_mask_en_i & err_irq_i};

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    uart_dma_thr_dec #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_thr (
      .sel_i (sel[g]),
      .thr_o (thr[g])
    );

    uart_dma_dir #(.DEPTH(DEPTH), .LVL_W(LVL_W), .IS_TX(g == 1)) u_dir (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en[g]),
      .gate_i   (gate[g]),
      .clr_i    (clr[g]),
      .level_i  (level[g]),
      .thr_i    (thr[g]),
      .single_o (single[g]),
      .burst_o  (burst[g])
    );
  end

  assign rx_single_o = single[0];
  assign rx_burst_o  = burst[0];
  assign tx_single_o = single[1];
  assign tx_burst_o  = burst[1];

  // R7
  err_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_mask_en_i && err_irq_i) |=> (!rx_single_o && !rx_burst_o));

  // R2 R8
  rx_single_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dma_en_i && !rx_clr_i && !(err_mask_en_i && err_irq_i) && rx_level_i != '0)
      |=> rx_single_o);

  // R4 R9
  tx_single_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dma_en_i && !tx_clr_i && tx_level_i < LVL_W'(DEPTH)) |=> tx_single_o);
endmodule

// File: tb/sim_uart_dma_req.sv
`timescale 1ns/1ps
module sim_uart_dma_req;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_dma_en_i = 1'b0, tx_dma_en_i = 1'b0;
  logic       err_mask_en_i = 1'b0, err_irq_i = 1'b0;
  logic [4:0] rx_level_i = '0, tx_level_i = '0;
  logic [2:0] rx_thr_sel_i = '0, tx_thr_sel_i = '0;
  logic       rx_clr_i = 1'b0, tx_clr_i = 1'b0;
  logic       rx_single_o, rx_burst_o, tx_single_o, tx_burst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  uart_dma_req u0 (.*);

  // {rx_level, tx_level, rx_sel, tx_sel, exp{rx_s,rx_b,tx_s,tx_b}}
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {5'd0,  5'd16, 3'd0, 3'd0, 4'b0000}, // R2 R4 empty rx, full tx
    {5'd1,  5'd15, 3'd0, 3'd0, 4'b1010}, // R3 R5 below 2
    {5'd2,  5'd14, 3'd0, 3'd0, 4'b1111}, // R6 sel0 = 2
    {5'd3,  5'd13, 3'd1, 3'd1, 4'b1010},
    {5'd4,  5'd12, 3'd1, 3'd1, 4'b1111}, // R6 sel1 = 4
    {5'd7,  5'd9,  3'd2, 3'd2, 4'b1010},
    {5'd8,  5'd8,  3'd2, 3'd2, 4'b1111}, // R6 sel2 = 8
    {5'd11, 5'd5,  3'd3, 3'd3, 4'b1010},
    {5'd12, 5'd4,  3'd3, 3'd3, 4'b1111}, // R6 sel3 = 12
    {5'd13, 5'd3,  3'd4, 3'd4, 4'b1010},
    {5'd14, 5'd2,  3'd4, 3'd4, 4'b1111}, // R6 sel4 = 14
    {5'd16, 5'd0,  3'd4, 3'd0, 4'b1111}, // R4 R2 full rx, empty tx
    {5'd9,  5'd16, 3'd5, 3'd7, 4'b1100}, // R6 reserved = 8
    {5'd7,  5'd8,  3'd6, 3'd5, 4'b1011}, // R6 reserved = 8
    {5'd0,  5'd0,  3'd0, 3'd4, 4'b0011}
  };

  function automatic logic [3:0] outs();
    return {rx_single_o, rx_burst_o, tx_single_o, tx_burst_o};
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rx_level_i = 5'd16;
    tx_level_i = 5'd0;
    rx_dma_en_i = 1'b1;
    tx_dma_en_i = 1'b1;
    step();
    step();
    check("R1 reset", 4'b0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {rx_level_i, tx_level_i, rx_thr_sel_i, tx_thr_sel_i} = VEC[i][19:4];
      step();
      check($sformatf("R2 R3 R4 R5 R6 vec%0d", i), VEC[i][3:0]);
    end

    // Baseline: rx 8 with sel 1/2, tx 0 with sel 1/2 -> all set
    rx_level_i = 5'd8; tx_level_i = 5'd0;
    rx_thr_sel_i = 3'd2; tx_thr_sel_i = 3'd2;
    step();
    check("R2 baseline", 4'b1111);

    // R11 enables
    rx_dma_en_i = 1'b0;
    step();
    check("R11 rx disabled", 4'b0011);
    rx_dma_en_i = 1'b1; tx_dma_en_i = 1'b0;
    step();
    check("R11 tx disabled", 4'b1100);
    tx_dma_en_i = 1'b1;

    // R8 interrupt without mask enable
    err_irq_i = 1'b1;
    step();
    check("R8 irq unmasked", 4'b1111);

    // R7 R9 gated receive
    err_mask_en_i = 1'b1;
    step();
    check("R7 R9 gated", 4'b0011);
    step();
    step();
    check("R7 held", 4'b0011);
    err_irq_i = 1'b0;
    step();
    check("R7 released", 4'b1111);

    // R10 clear pulses
    rx_clr_i = 1'b1;
    step();
    rx_clr_i = 1'b0;
    check("R10 rx clr", 4'b0011);
    step();
    check("R10 rx reeval", 4'b1111);
    tx_clr_i = 1'b1;
    step();
    tx_clr_i = 1'b0;
    check("R10 tx clr", 4'b1100);
    step();
    check("R10 tx reeval", 4'b1111);

    // Coincident: irq falls in the same cycle as rx clear (R7 R10)
    err_irq_i = 1'b1;
    step();
    check("R7 gate again", 4'b0011);
    err_irq_i = 1'b0; rx_clr_i = 1'b1;
    step();
    rx_clr_i = 1'b0;
    check("R7 R10 coincident", 4'b0011);
    step();
    check("R7 R10 after", 4'b1111);

    // tx clear while rx gated (R9 R10)
    err_irq_i = 1'b1; tx_clr_i = 1'b1;
    step();
    tx_clr_i = 1'b0;
    check("R9 R10 tx clr gated", 4'b0000);
    step();
    check("R9 tx back", 4'b0011);
    err_irq_i = 1'b0;
    step();
    check("R7 final", 4'b1111);

    // R1 reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R1 async reset", 4'b0000);
    step();
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule